// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects up to eight interrupt request lines, resolves them with a fixed priority in which line 0 wins, and signals the processor through a single interrupt output. When the processor strobes its acknowledge input, the block returns an 8-bit vector built from a programmed base and the winning line number. It also moves that line from the pending set into the in-service set, unless automatic end-of-interrupt has been chosen. Software drives the block through a two-address register port: a command address and a data address.

Programming begins with a command write that has bit 4 set. Up to three data writes follow. They set the vector base, the cascade wiring (a bit mask of slave-bearing lines for a master, a 3-bit identity for a slave) and the end-of-interrupt mode. Outside that sequence, data writes load the interrupt mask, and command writes issue end-of-interrupt commands or choose which register a status read returns. If an acknowledge arrives with nothing left to grant, because the request line dropped after the interrupt output rose, the block answers with the line-7 vector and marks nothing in service.

Top module: `irq_ctrl8`

## Requirements
- R1: Reset clears the request and in-service registers, sets the mask to 0xFF, selects the request register for status reads, holds `int_out` and `vec_valid` low, and clears the cascade setting and the auto-EOI mode.
- R2: A rising edge on `irq_in[n]` sets request bit n, which is then held only while the line stays high. A command-address read (`port_sel`=0) returns the request register while the request register is selected.
- R3: Outside an initialization sequence, a data-address write (`port_sel`=1) loads the mask, and a data-address read returns it. A masked line still shows in the request register but never raises `int_out`.
- R4: `int_out` is high when the lowest-numbered unmasked pending line has a lower number than every in-service line. One cycle after `ack_in`, `vec_valid` pulses and `vec_out` = {base[7:3], line[2:0]}.
- R5: In normal EOI mode, an acknowledge that grants line n sets in-service bit n and clears request bit n.
- R6: An acknowledge made while nothing is grantable returns {base[7:3], 3'd7} and leaves the in-service register unchanged.
- R7: A command write with bit 4 set starts initialization. It clears the in-service register, turns auto-EOI off and selects the request register, and it leaves the mask unchanged. The next data write takes bits 7:3 as the vector base. Bit 1 of the start word set skips the cascade word. Bit 0 clear skips the mode word, and the following data write then loads the mask.
- R8: In the cascade word, a master (`is_master`=1) keeps all 8 bits and a slave keeps bits 2:0 only. The stored value appears on `cascade_cfg`.
- R9: Bit 1 of the mode word enables auto-EOI. An acknowledge then clears the granted request bit and sets no in-service bit.
- R10: A command write of 0x60 + L (L in 0..7) clears exactly in-service bit L.
- R11: A command write with bits 7:5 = 001 (0x20) clears only the lowest-numbered set in-service bit.
- R12: A command write of 0x0B selects the in-service register for command-address reads, and 0x0A selects the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, line 0 highest priority |
| is_master | input | 1 | Role for the cascade word: 1 master, 0 slave |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| port_sel | input | 1 | 0 command address, 1 data address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data: selected status register (command) or mask (data) |
| ack_in | input | 1 | Processor acknowledge strobe, one cycle |
| int_out | output | 1 | Interrupt output to the processor |
| vec_out | output | 8 | Vector captured at acknowledge |
| vec_valid | output | 1 | One-cycle pulse marking `vec_out` as fresh |
| cascade_cfg | output | 8 | Stored cascade word (master mask or slave identity) |

## Verification
A request edge and a register write each take effect at the first clock edge that samples them. `int_out` and `rd_data` are combinational from the registers, so they are valid in the same cycle that follows the edge. The vector and its valid pulse, along with the in-service update, appear one edge after the acknowledge strobe. The bench drives every input at a falling edge and samples after the next falling edge, one rising edge later, and it reads status a short delay after the address select settles. Sweeps over all eight lines and all 28 line pairs compute vectors from the programmed base and the line number.

// File: rtl/irq_ctrl8_pkg.sv
// Shared types and command encodings for the eight-line interrupt controller.
package irq_ctrl8_pkg;
    // Initialization sequencer position
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BASE  = 2'd1,
        ST_CASC  = 2'd2,
        ST_MODE  = 2'd3
    } init_st_t;

    localparam logic [4:0] CMD_SEOI_TOP  = 5'b01100; // 0x60..0x67
    localparam logic [2:0] CMD_NSEOI_TOP = 3'b001;   // 0x20..0x3F with bits 4:3 = 0
    localparam int         START_BIT     = 4;
    localparam int         SKIP_CASC_BIT = 1;
    localparam int         NEED_MODE_BIT = 0;
    localparam int         AEOI_BIT      = 1;
endpackage

// File: rtl/irq_req_latch.sv
// Request register: captures rising edges of the request lines and holds each
// bit only while its line stays high; an acknowledge clears the granted bit.
// Assumes lines are synchronous to clk.
module irq_req_latch #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic [LINES-1:0] clr,
    output logic [LINES-1:0] irr
);
    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] rise;

    // Edge detect against last cycle's line levels
    assign rise = lines & ~prev_q;

    // Latch edges, drop bits whose line fell or that were acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '1;
            irr    <= '0;
        end else begin
            prev_q <= lines;
            irr    <= ((irr & ~clr) | rise) & lines;
        end
    end

    AST_IRR_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (irr & ~$past(lines)) == '0); // R2
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority finder: reports whether any bit is set and the lowest set index.
// Purely combinational.
module irq_prio_pick #(
    parameter int LINES = 8,
    localparam int LVL_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    output logic             any,
    output logic [LVL_W-1:0] lvl
);
    // Scan from the top down so the lowest set index is kept last
    always_comb begin
        any = 1'b0;
        lvl = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                lvl = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_cfg_regs.sv
// Register port decoder: runs the initialization word sequence, holds mask,
// vector base, cascade word, auto-EOI mode and status select, and turns
// command writes into EOI pulses. Assumes one-cycle write strobes.
module irq_cfg_regs
    import irq_ctrl8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINES  = 8,
    localparam int LVL_W = $clog2(LINES),
    localparam int VB_W  = DATA_W - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              wr_en,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LINES-1:0]  mask_q,
    output logic [VB_W-1:0]   vbase_q,
    output logic [DATA_W-1:0] casc_q,
    output logic              aeoi_q,
    output logic              sel_isr_q,
    output logic              init_start,
    output logic              eoi_spec,
    output logic              eoi_any,
    output logic [LVL_W-1:0]  eoi_lvl
);
    init_st_t st_q;
    logic     need_casc_q, need_mode_q;
    logic     cmd_wr, dat_wr;

    // Address decode
    assign cmd_wr     = wr_en && !port_sel;
    assign dat_wr     = wr_en &&  port_sel;
    assign init_start = cmd_wr && wr_data[START_BIT];
    assign eoi_spec   = cmd_wr && wr_data[DATA_W-1:LVL_W] == CMD_SEOI_TOP;
    assign eoi_any    = cmd_wr && wr_data[7:5] == CMD_NSEOI_TOP && wr_data[4:3] == 2'b00;
    assign eoi_lvl    = wr_data[LVL_W-1:0];

    // Sequencer and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_RUN;
            need_casc_q <= 1'b0;
            need_mode_q <= 1'b0;
            mask_q      <= '1;
            vbase_q     <= '0;
            casc_q      <= '0;
            aeoi_q      <= 1'b0;
            sel_isr_q   <= 1'b0;
        end else if (init_start) begin
            st_q        <= ST_BASE;
            need_casc_q <= !wr_data[SKIP_CASC_BIT];
            need_mode_q <= wr_data[NEED_MODE_BIT];
            aeoi_q      <= 1'b0;
            sel_isr_q   <= 1'b0;
        end else if (cmd_wr) begin
            if (wr_data[4:3] == 2'b01 && wr_data[1])
                sel_isr_q <= wr_data[0];
        end else if (dat_wr) begin
            case (st_q)
                ST_RUN: mask_q <= wr_data[LINES-1:0];
                ST_BASE: begin
                    vbase_q <= wr_data[DATA_W-1:LVL_W];
                    st_q    <= need_casc_q ? ST_CASC : (need_mode_q ? ST_MODE : ST_RUN);
                end
                ST_CASC: begin
                    casc_q <= is_master ? wr_data : {{(DATA_W-3){1'b0}}, wr_data[2:0]};
                    st_q   <= need_mode_q ? ST_MODE : ST_RUN;
                end
                default: begin
                    aeoi_q <= wr_data[AEOI_BIT];
                    st_q   <= ST_RUN;
                end
            endcase
        end
    end

    AST_RESET_MASK: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1 && !sel_isr_q && !aeoi_q)); // R1
    AST_INIT_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN) |=> $stable(mask_q)); // R7
endmodule

// File: rtl/irq_ctrl8.sv
// Eight-line interrupt controller top: fixed priority (line 0 highest),
// in-service tracking with specific, non-specific and automatic EOI, vector
// issue on acknowledge and line-7 spurious answer. Assumes ack_in is a
// one-cycle strobe synchronous to clk.
module irq_ctrl8
    import irq_ctrl8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINES  = 8,
    localparam int LVL_W = $clog2(LINES),
    localparam int VB_W  = DATA_W - LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic              is_master,
    input  logic              wr_en,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ack_in,
    output logic              int_out,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_valid,
    output logic [DATA_W-1:0] cascade_cfg
);
    logic [LINES-1:0] irr_q, isr_q, isr_nx, mask_q, ack_clr;
    logic [VB_W-1:0]  vbase_q;
    logic             aeoi_q, sel_isr_q, init_start, eoi_spec, eoi_any;
    logic [LVL_W-1:0] eoi_lvl, req_lvl, isr_lvl;
    logic             req_any, isr_any, grant;

    irq_cfg_regs #(.DATA_W(DATA_W), .LINES(LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .wr_en(wr_en),
        .port_sel(port_sel), .wr_data(wr_data), .mask_q(mask_q),
        .vbase_q(vbase_q), .casc_q(cascade_cfg), .aeoi_q(aeoi_q),
        .sel_isr_q(sel_isr_q), .init_start(init_start), .eoi_spec(eoi_spec),
        .eoi_any(eoi_any), .eoi_lvl(eoi_lvl)
    );

    irq_req_latch #(.LINES(LINES)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_in), .clr(ack_clr), .irr(irr_q)
    );

    irq_prio_pick #(.LINES(LINES)) u_pick_req (
        .vec(irr_q & ~mask_q), .any(req_any), .lvl(req_lvl)
    );

    irq_prio_pick #(.LINES(LINES)) u_pick_isr (
        .vec(isr_q), .any(isr_any), .lvl(isr_lvl)
    );

    // A pending line wins only if it outranks everything in service
    assign grant   = req_any && (!isr_any || req_lvl < isr_lvl);
    assign int_out = grant;
    assign ack_clr = (ack_in && grant) ? (LINES'(1) << req_lvl) : '0;

    // Status read mux
    assign rd_data = port_sel ? DATA_W'(mask_q) : DATA_W'(sel_isr_q ? isr_q : irr_q);

    // Next in-service set: EOIs clear, a normal-mode acknowledge sets
    always_comb begin
        isr_nx = isr_q;
        if (eoi_spec)
            isr_nx[eoi_lvl] = 1'b0;
        if (eoi_any && isr_any)
            isr_nx[isr_lvl] = 1'b0;
        if (ack_in && grant && !aeoi_q)
            isr_nx[req_lvl] = 1'b1;
        if (init_start)
            isr_nx = '0;
    end

    // In-service register and vector capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q     <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            isr_q     <= isr_nx;
            vec_valid <= ack_in;
            if (ack_in)
                vec_out <= {vbase_q, grant ? req_lvl : LVL_W'(LINES - 1)};
        end
    end

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_in)); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_q & ~mask_q) != '0)); // R3
    AST_SPURIOUS_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && !int_out && !wr_en) |=> (isr_q == $past(isr_q))); // R6
    AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && aeoi_q && !wr_en) |=> $stable(isr_q)); // R9
    AST_SEOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !port_sel && wr_data[7:3] == 5'b01100 && !ack_in)
        |=> !isr_q[$past(wr_data[2:0])]); // R10
endmodule

// File: tb/irq_ctrl8_tb.sv
module irq_ctrl8_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = 8'h00;
    logic       is_master = 1'b1;
    logic       wr_en = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ack_in = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [7:0] cascade_cfg;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl8 u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .is_master(is_master),
        .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data), .rd_data(rd_data),
        .ack_in(ack_in), .int_out(int_out), .vec_out(vec_out),
        .vec_valid(vec_valid), .cascade_cfg(cascade_cfg)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; port_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_lines(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack_in = 1'b1;
        @(negedge clk);
        ack_in = 1'b0;
    endtask

    task automatic status(input logic isr, output logic [7:0] v);
        wr(1'b0, isr ? 8'h0B : 8'h0A);
        port_sel = 1'b0; #1; v = rd_data;
    endtask

    task automatic mask_rd(output logic [7:0] v);
        port_sel = 1'b1; #1; v = rd_data;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        chk("R1 cascade", cascade_cfg, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        mask_rd(v);  chk("R1 mask", v, 8'hFF);
        port_sel = 1'b0; #1; chk("R1 irr default select", rd_data, 8'h00);
        // R3 masked line latched but silent; R2 default select shows request
        set_lines(8'h01);
        port_sel = 1'b0; #1; chk("R2 irr after edge", rd_data, 8'h01);
        chk("R3 masked int_out", {7'd0, int_out}, 8'h00);
        status(1'b1, v); chk("R1 isr zero", v, 8'h00);
        set_lines(8'h00);
        status(1'b0, v); chk("R2 irr drops with line", v, 8'h00);

        // R7/R8 master init, normal EOI
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        chk("R8 master cascade", cascade_cfg, 8'h04);
        mask_rd(v); chk("R7 mask kept through init", v, 8'hFF);
        wr(1'b1, 8'h00);
        mask_rd(v); chk("R3 mask load", v, 8'h00);

        // Single-line sweep: R2 R4 R5 R10 R12
        for (int l = 0; l < 8; l++) begin
            set_lines(8'(1 << l));
            chk("R4 int_out single", {7'd0, int_out}, 8'h01);
            status(1'b0, v); chk("R12 irr select", v, 8'(1 << l));
            do_ack();
            chk("R4 vec_valid", {7'd0, vec_valid}, 8'h01);
            chk("R4 vector", vec_out, 8'h20 + 8'(l));
            status(1'b1, v); chk("R5 isr set", v, 8'(1 << l));
            status(1'b0, v); chk("R5 irr cleared", v, 8'h00);
            wr(1'b0, 8'h60 + 8'(l));
            status(1'b1, v); chk("R10 specific eoi", v, 8'h00);
            set_lines(8'h00);
        end

        // Pair sweep: R4 priority, R10 exactness, R11 lowest-first
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                set_lines(8'((1 << a) | (1 << b)));
                do_ack();
                chk("R4 higher wins", vec_out, 8'h20 + 8'(a));
                chk("R4 lower blocked", {7'd0, int_out}, 8'h00);
                wr(1'b0, 8'h20);
                chk("R11 unblocked", {7'd0, int_out}, 8'h01);
                do_ack();
                chk("R4 second vector", vec_out, 8'h20 + 8'(b));
                wr(1'b0, 8'h20);
                status(1'b1, v); chk("R11 isr empty", v, 8'h00);
                set_lines(8'h00);
                // nesting: b in service, then a preempts
                set_lines(8'(1 << b));
                do_ack();
                set_lines(8'((1 << a) | (1 << b)));
                chk("R4 preempt", {7'd0, int_out}, 8'h01);
                do_ack();
                chk("R4 preempt vector", vec_out, 8'h20 + 8'(a));
                wr(1'b0, 8'h60 + 8'(b));
                status(1'b1, v); chk("R10 only level b", v, 8'(1 << a));
                wr(1'b0, 8'h20);
                status(1'b1, v); chk("R11 clears a", v, 8'h00);
                set_lines(8'h00);
            end
        end

        // R3 mask sweep
        for (int l = 0; l < 8; l++) begin
            wr(1'b1, 8'(1 << l));
            set_lines(8'(1 << l));
            chk("R3 masked quiet", {7'd0, int_out}, 8'h00);
            wr(1'b1, 8'h00);
            chk("R3 unmasked fires", {7'd0, int_out}, 8'h01);
            do_ack();
            chk("R3 vector", vec_out, 8'h20 + 8'(l));
            wr(1'b0, 8'h20);
            set_lines(8'h00);
        end

        // R6 spurious: request vanishes before acknowledge
        set_lines(8'h08);
        chk("R6 int_out up", {7'd0, int_out}, 8'h01);
        set_lines(8'h00);
        do_ack();
        chk("R6 spurious vector", vec_out, 8'h27);
        chk("R6 spurious valid", {7'd0, vec_valid}, 8'h01);
        status(1'b1, v); chk("R6 no isr", v, 8'h00);

        // R7 init clears ISR; single mode skips cascade word; R9 auto-EOI
        set_lines(8'h40);
        do_ack();
        set_lines(8'h00);
        status(1'b1, v); chk("R7 isr before reinit", v, 8'h40);
        wr(1'b0, 8'h13); wr(1'b1, 8'h2F); wr(1'b1, 8'h03);
        port_sel = 1'b0; #1; chk("R7 select reset to irr", rd_data, 8'h00);
        status(1'b1, v); chk("R7 isr cleared", v, 8'h00);
        chk("R7 cascade skipped", cascade_cfg, 8'h04);
        mask_rd(v); chk("R7 mode word not mask", v, 8'h00);
        for (int l = 0; l < 8; l++) begin
            set_lines(8'(1 << l));
            do_ack();
            chk("R9 aeoi vector base 0x28", vec_out, 8'h28 + 8'(l));
            status(1'b1, v); chk("R9 no isr", v, 8'h00);
            chk("R9 no refire", {7'd0, int_out}, 8'h00);
            set_lines(8'h00);
        end

        // R8 slave identity; mode word off turns auto-EOI off
        is_master = 1'b0;
        wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'hFA); wr(1'b1, 8'h01);
        chk("R8 slave id", cascade_cfg, 8'h02);
        set_lines(8'h20);
        do_ack();
        chk("R9 off vector", vec_out, 8'h2D);
        status(1'b1, v); chk("R9 off isr set", v, 8'h20);
        set_lines(8'h00);

        // R7 no mode word: the data write after the cascade word is the mask
        is_master = 1'b1;
        wr(1'b0, 8'h10); wr(1'b1, 8'h20); wr(1'b1, 8'h03); wr(1'b1, 8'h55);
        chk("R8 cascade", cascade_cfg, 8'h03);
        mask_rd(v); chk("R7 mask after short init", v, 8'h55);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule